// File: doc/BRIEF.md
# Rate-converter error status register

This block assembles the 32-bit read-only error word of a four-channel audio sample-rate converter. It watches the direct-access links that move samples between the converter and audio peripherals, checks the peripheral-selection map for collisions and out-of-range indices, and gates a set of precomputed mode-compatibility results on whether any DSP is running. Overflow, memory-check and configuration-code inputs from neighbouring blocks are placed in their fields unchanged.

Two kinds of flag live in the word. Link transfer errors are sticky: once raised they hold until the word is read, and the read strobe clears them on the following clock. Every other flag is live and follows its inputs, so it falls away as soon as software repairs the settings. The read data is combinational from the sticky state and the live inputs, so a bus port samples it in the same cycle as the read strobe.

Top module: `src_err_status`

## Requirements
- R1: While reset is asserted and all inputs are idle, the word reads 0x00000000.
- R2: For an output channel c with its link enabled, a trigger arriving when a previous trigger was seen since enabling and no output data strobe occurred since that trigger (a data strobe in the same cycle as the trigger counts) sets bit 28+c. A disabled channel forgets its previous trigger.
- R3: The same missing-data rule on input channel c, using its input trigger, input data strobe and input link enable, sets bit 24+c.
- R4: A valid sync on input link c while that channel's input direct access is disabled sets bit 24+c.
- R5: Input direct access on channel c going from enabled to disabled while data is pending on its link sets bit 24+c.
- R6: Bits 31:24 are sticky; a read strobe clears them in the cycle after the strobe, and an error event in the cycle of the strobe leaves the bit set.
- R7: Bits 23 (output trigger), 22 (input trigger), 21 (receive link setup) and 20 (transmit link setup) follow their incompatibility inputs while at least one DSP enable is high, and read zero when all DSP enables are low.
- R8: Bit 19 is set while two enabled output channels select the same peripheral index; bit 18 likewise for input channels. Disabled channels take no part.
- R9: Bit 17 is set while an enabled output channel selects an index above MAX_IDX (default 3); bit 16 likewise for input channels. Disabled channels are ignored.
- R10: Bit 15 carries the overflow input, bits 12:8 the output configuration code, bit 7 the ROM check result, bit 6 the SRAM check result, bits 4:0 the input configuration code; bits 14:13 and bit 5 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_i | input | 1 | Read strobe of the status word |
| rdata_o | output | 32 | Status word |
| trig_out_i | input | 4 | Output-side trigger event per channel |
| trig_in_i | input | 4 | Input-side trigger event per channel |
| dat_out_i | input | 4 | Output data transfer strobe per channel |
| dat_in_i | input | 4 | Input data transfer strobe per channel |
| link_sync_i | input | 4 | Sync event valid on input link per channel |
| link_pend_i | input | 4 | Data pending on input link per channel |
| da_out_en_i | input | 4 | Output direct-access enable per channel |
| da_in_en_i | input | 4 | Input direct-access enable per channel |
| dsp_en_i | input | 4 | DSP enable per channel |
| sel_out_i | input | 12 | Output peripheral index per channel, 3 bits each, channel 0 in the low bits |
| sel_in_i | input | 12 | Input peripheral index per channel, 3 bits each, channel 0 in the low bits |
| otrig_bad_i | input | 1 | Output trigger setup incompatible |
| itrig_bad_i | input | 1 | Input trigger setup incompatible |
| rx_cfg_bad_i | input | 1 | Receive link setup incompatible |
| tx_cfg_bad_i | input | 1 | Transmit link setup incompatible |
| dsp_ovf_i | input | 1 | DSP overflow |
| rom_fail_i | input | 1 | ROM check failed |
| sram_fail_i | input | 1 | SRAM check failed |
| out_code_i | input | 5 | Output configuration code |
| in_code_i | input | 5 | Input configuration code |

## Verification
The bench targets a read strobe that coincides with a new link error: a design clearing after setting would lose that error. It drives a data strobe in the same cycle as the closing trigger, which a design ignoring that strobe would wrongly flag, and a first trigger after enabling, which a design without the armed state would flag. It toggles DSP enables under bad setups to catch ungated or stale live flags, and places duplicate and over-range indices on disabled channels, where a design ignoring the enables would raise collision or range flags.

// File: rtl/src_err_pkg.sv
package src_err_pkg;
  localparam int NCH   = 4;
  localparam int SELW  = 3;
  localparam int CODEW = 5;
  localparam int MAXI  = 3;
endpackage

// File: rtl/src_xfer_mon.sv
module src_xfer_mon #(
  parameter bit CHK_LINK = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic trig_i,
  input  logic dat_i,
  input  logic sync_i,
  input  logic pend_i,
  output logic err_o
);
  logic armed_q, got_q, en_q;
  logic miss, link;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      got_q   <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      en_q <= en_i;
      if (!en_i) begin
        armed_q <= 1'b0;
        got_q   <= 1'b0;
      end else if (trig_i) begin
        armed_q <= 1'b1;
        got_q   <= 1'b0;
      end else if (dat_i) begin
        got_q <= 1'b1;
      end
    end
  end

  // data in the trigger cycle closes the current window
  assign miss  = en_i & trig_i & armed_q & ~(got_q | dat_i);
  assign link  = CHK_LINK & ((sync_i & ~en_i) | (en_q & ~en_i & pend_i));
  assign err_o = miss | link;
endmodule

// File: rtl/src_sticky.sv
module src_sticky #(
  parameter int NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic [NB-1:0] set_i,
  output logic [NB-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~{NB{rd_i}}) | set_i;
  end
endmodule

// File: rtl/src_sel_check.sv
module src_sel_check #(
  parameter int NCH     = 4,
  parameter int SELW    = 3,
  parameter int MAX_IDX = 3
) (
  input  logic [NCH-1:0]      en_i,
  input  logic [NCH*SELW-1:0] sel_i,
  output logic                dup_o,
  output logic                over_o
);
  localparam logic [SELW-1:0] MAX_SEL = SELW'(MAX_IDX);

  logic [SELW-1:0] sel [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_unpack
    assign sel[g] = sel_i[g*SELW +: SELW];
  end

  always_comb begin
    dup_o  = 1'b0;
    over_o = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (en_i[i] && (sel[i] > MAX_SEL)) over_o = 1'b1;
      for (int j = i + 1; j < NCH; j++) begin
        if (en_i[i] && en_i[j] && (sel[i] == sel[j])) dup_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/src_err_status.sv
module src_err_status #(
  parameter int NCH     = src_err_pkg::NCH,
  parameter int SELW    = src_err_pkg::SELW,
  parameter int CODEW   = src_err_pkg::CODEW,
  parameter int MAX_IDX = src_err_pkg::MAXI
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rd_i,
  output logic [31:0]         rdata_o,
  input  logic [NCH-1:0]      trig_out_i,
  input  logic [NCH-1:0]      trig_in_i,
  input  logic [NCH-1:0]      dat_out_i,
  input  logic [NCH-1:0]      dat_in_i,
  input  logic [NCH-1:0]      link_sync_i,
  input  logic [NCH-1:0]      link_pend_i,
  input  logic [NCH-1:0]      da_out_en_i,
  input  logic [NCH-1:0]      da_in_en_i,
  input  logic [NCH-1:0]      dsp_en_i,
  input  logic [NCH*SELW-1:0] sel_out_i,
  input  logic [NCH*SELW-1:0] sel_in_i,
  input  logic                otrig_bad_i,
  input  logic                itrig_bad_i,
  input  logic                rx_cfg_bad_i,
  input  logic                tx_cfg_bad_i,
  input  logic                dsp_ovf_i,
  input  logic                rom_fail_i,
  input  logic                sram_fail_i,
  input  logic [CODEW-1:0]    out_code_i,
  input  logic [CODEW-1:0]    in_code_i
);
  logic [NCH-1:0] out_ev, in_ev, out_q, in_q;
  logic out_dup, out_over, in_dup, in_over, live;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    src_xfer_mon #(.CHK_LINK(1'b0)) u_out (
      .clk_i, .rst_ni,
      .en_i(da_out_en_i[c]), .trig_i(trig_out_i[c]), .dat_i(dat_out_i[c]),
      .sync_i(1'b0), .pend_i(1'b0), .err_o(out_ev[c])
    );
    src_xfer_mon #(.CHK_LINK(1'b1)) u_in (
      .clk_i, .rst_ni,
      .en_i(da_in_en_i[c]), .trig_i(trig_in_i[c]), .dat_i(dat_in_i[c]),
      .sync_i(link_sync_i[c]), .pend_i(link_pend_i[c]), .err_o(in_ev[c])
    );
  end

  src_sticky #(.NB(NCH)) u_out_st (
    .clk_i, .rst_ni, .rd_i, .set_i(out_ev), .q_o(out_q)
  );
  src_sticky #(.NB(NCH)) u_in_st (
    .clk_i, .rst_ni, .rd_i, .set_i(in_ev), .q_o(in_q)
  );

  src_sel_check #(.NCH(NCH), .SELW(SELW), .MAX_IDX(MAX_IDX)) u_sel_out (
    .en_i(da_out_en_i), .sel_i(sel_out_i), .dup_o(out_dup), .over_o(out_over)
  );
  src_sel_check #(.NCH(NCH), .SELW(SELW), .MAX_IDX(MAX_IDX)) u_sel_in (
    .en_i(da_in_en_i), .sel_i(sel_in_i), .dup_o(in_dup), .over_o(in_over)
  );

  assign live = |dsp_en_i;

  assign rdata_o = {out_q, in_q,
                    otrig_bad_i & live, itrig_bad_i & live,
                    rx_cfg_bad_i & live, tx_cfg_bad_i & live,
                    out_dup, in_dup, out_over, in_over,
                    dsp_ovf_i, 2'b00, out_code_i,
                    rom_fail_i, sram_fail_i, 1'b0, in_code_i};
endmodule

// File: rtl/src_err_status_chk.sv
module src_err_status_chk #(
  parameter int NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           rd_i,
  input logic [31:0]    rdata_o,
  input logic [NCH-1:0] dsp_en_i,
  input logic [NCH-1:0] da_in_en_i,
  input logic [NCH-1:0] da_out_en_i
);
  assert_sticky_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ((rdata_o[31:24] & $past(rdata_o[31:24])) == $past(rdata_o[31:24])));

  assert_live_gate_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dsp_en_i == '0) |-> (rdata_o[23:20] == 4'b0000));

  assert_reserved_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[14:13] == 2'b00) && !rdata_o[5]);

  // R9 as well: no enabled channel, no selection flag
  assert_in_sel_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_in_en_i == '0) |-> (!rdata_o[18] && !rdata_o[16]));

  assert_out_sel_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (da_out_en_i == '0) |-> (!rdata_o[19] && !rdata_o[17]));
endmodule

bind src_err_status src_err_status_chk #(.NCH(NCH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rd_i(rd_i), .rdata_o(rdata_o),
  .dsp_en_i(dsp_en_i), .da_in_en_i(da_in_en_i), .da_out_en_i(da_out_en_i)
);

// File: tb/tb_src_err_status.sv
module tb_src_err_status;
  localparam int MAXI = 3;

  logic clk = 1'b0, rst_n = 1'b0, rd = 1'b0;
  logic [3:0] trig_out = '0, trig_in = '0, dat_out = '0, dat_in = '0;
  logic [3:0] link_sync = '0, link_pend = '0, dout_en = '0, din_en = '0, dsp_en = '0;
  logic [11:0] sel_out = '0, sel_in = '0;
  logic otrig_bad = 0, itrig_bad = 0, rx_bad = 0, tx_bad = 0;
  logic ovf = 0, rom = 0, sram = 0;
  logic [4:0] ocode = '0, icode = '0;
  logic [31:0] rdata;

  int checks = 0, errors = 0, cyc = 0;

  always #5 clk = ~clk;

  src_err_status dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .rdata_o(rdata),
    .trig_out_i(trig_out), .trig_in_i(trig_in), .dat_out_i(dat_out), .dat_in_i(dat_in),
    .link_sync_i(link_sync), .link_pend_i(link_pend),
    .da_out_en_i(dout_en), .da_in_en_i(din_en), .dsp_en_i(dsp_en),
    .sel_out_i(sel_out), .sel_in_i(sel_in),
    .otrig_bad_i(otrig_bad), .itrig_bad_i(itrig_bad),
    .rx_cfg_bad_i(rx_bad), .tx_cfg_bad_i(tx_bad),
    .dsp_ovf_i(ovf), .rom_fail_i(rom), .sram_fail_i(sram),
    .out_code_i(ocode), .in_code_i(icode)
  );

  // reference model state
  bit m_arm_o [4], m_got_o [4], m_arm_i [4], m_got_i [4], m_en_q [4];
  bit [3:0] m_dao = '0, m_dai = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin
        m_arm_o[c] = 0; m_got_o[c] = 0; m_arm_i[c] = 0; m_got_i[c] = 0; m_en_q[c] = 0;
      end
      m_dao = '0; m_dai = '0;
    end else begin
      bit [3:0] ev_o, ev_i;
      ev_o = '0; ev_i = '0;
      for (int c = 0; c < 4; c++) begin
        if (dout_en[c]) begin
          if (trig_out[c]) begin
            if (m_arm_o[c] && !m_got_o[c] && !dat_out[c]) ev_o[c] = 1;
            m_arm_o[c] = 1; m_got_o[c] = 0;
          end else if (dat_out[c]) m_got_o[c] = 1;
        end else begin
          m_arm_o[c] = 0; m_got_o[c] = 0;
        end
        if (din_en[c]) begin
          if (trig_in[c]) begin
            if (m_arm_i[c] && !m_got_i[c] && !dat_in[c]) ev_i[c] = 1;
            m_arm_i[c] = 1; m_got_i[c] = 0;
          end else if (dat_in[c]) m_got_i[c] = 1;
        end else begin
          m_arm_i[c] = 0; m_got_i[c] = 0;
          if (link_sync[c]) ev_i[c] = 1;
          if (m_en_q[c] && link_pend[c]) ev_i[c] = 1;
        end
        m_en_q[c] = din_en[c];
      end
      if (rd) begin m_dao = '0; m_dai = '0; end
      m_dao |= ev_o;
      m_dai |= ev_i;
    end
  end

  function automatic bit sel_dup(logic [3:0] en, logic [11:0] s);
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        if (i != j && en[i] && en[j] && s[i*3 +: 3] == s[j*3 +: 3]) return 1;
    return 0;
  endfunction

  function automatic bit sel_over(logic [3:0] en, logic [11:0] s);
    for (int i = 0; i < 4; i++)
      if (en[i] && int'(s[i*3 +: 3]) > MAXI) return 1;
    return 0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1", rdata, 32'h0);
    end else begin
      bit live;
      live = |dsp_en;
      chk("R2/R6", {28'h0, rdata[31:28]}, {28'h0, m_dao});
      chk("R3/R4/R5/R6", {28'h0, rdata[27:24]}, {28'h0, m_dai});
      chk("R7", {28'h0, rdata[23:20]},
          {28'h0, otrig_bad & live, itrig_bad & live, rx_bad & live, tx_bad & live});
      chk("R8", {30'h0, rdata[19:18]}, {30'h0, sel_dup(dout_en, sel_out), sel_dup(din_en, sel_in)});
      chk("R9", {30'h0, rdata[17:16]}, {30'h0, sel_over(dout_en, sel_out), sel_over(din_en, sel_in)});
      chk("R10", {16'h0, rdata[15:0]},
          {16'h0, ovf, 2'b00, ocode, rom, sram, 1'b0, icode});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++; checks++;
      $display("FAIL R1 watchdog actual=cycle %0d expected=completion", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
    trig_out = '0; trig_in = '0; dat_out = '0; dat_in = '0; link_sync = '0; rd = 0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R2: first trigger arms, data then trigger ok, bare trigger flags
    dout_en = 4'b0001; step();
    trig_out[0] = 1; step();
    dat_out[0] = 1; step();
    trig_out[0] = 1; step();
    trig_out[0] = 1; dat_out[0] = 1; step();
    trig_out[0] = 1; step();
    step(); step();
    rd = 1; step(); step();
    // R6: read in the same cycle as a new error
    trig_out[0] = 1; rd = 1; step(); step();
    rd = 1; step(); step();
    // R3: missing input data on channel 2
    din_en = 4'b0100; step();
    trig_in[2] = 1; step();
    trig_in[2] = 1; step(); step();
    // R4: sync while channel 1 disabled
    link_sync[1] = 1; step(); step();
    // R5: disable channel 2 with data pending
    link_pend = 4'b0100; din_en = 4'b0000; step();
    link_pend = '0; step();
    rd = 1; step(); step();
    // R7: live flags gated on DSP enables
    otrig_bad = 1; itrig_bad = 1; rx_bad = 1; tx_bad = 1; step();
    dsp_en = 4'b1000; step();
    itrig_bad = 0; step();
    dsp_en = 4'b0000; step();
    otrig_bad = 0; rx_bad = 0; tx_bad = 0;
    // R8: duplicate selections, enabled and disabled
    sel_in = {3'd0, 3'd0, 3'd2, 3'd2}; din_en = 4'b1100; step();
    din_en = 4'b0011; step();
    din_en = 4'b0001; step();
    sel_out = {3'd1, 3'd1, 3'd1, 3'd0}; dout_en = 4'b1001; step();
    dout_en = 4'b1010; step();
    // R9: over-range index
    sel_out = {3'd5, 3'd2, 3'd1, 3'd0}; dout_en = 4'b0111; step();
    dout_en = 4'b1000; step();
    sel_in = {3'd3, 3'd7, 3'd1, 3'd0}; din_en = 4'b1011; step();
    din_en = 4'b0100; step();
    // R10: pass-through fields
    ovf = 1; rom = 1; sram = 0; ocode = 5'd21; icode = 5'd10; step();
    ovf = 0; rom = 0; sram = 1; ocode = 5'd1; icode = 5'd31; step();
    // mixed random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [31:0] r;
      r = $urandom;
      trig_out = r[3:0] & r[7:4]; trig_in = r[11:8] & r[15:12];
      dat_out = r[19:16]; dat_in = r[23:20];
      link_sync = r[27:24] & r[31:28] & {4{r[0] & r[5]}};
      link_pend = r[7:4];
      rd = (r[15:10] == 6'd0);
      if (r[31:29] == 3'd0) begin
        r = $urandom;
        dout_en = r[3:0]; din_en = r[7:4]; dsp_en = r[11:8] & r[15:12];
        sel_out = r[23:12]; sel_in = {r[31:24], r[3:0]};
        {otrig_bad, itrig_bad, rx_bad, tx_bad, ovf, rom, sram} = r[30:24];
        ocode = r[20:16]; icode = r[28:24];
      end
      @(posedge clk); #1;
      trig_out = '0; trig_in = '0; dat_out = '0; dat_in = '0; link_sync = '0; rd = 0;
    end
    step();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule